// File: doc/BRIEF.md
# Keyboard Matrix Scanning Encoder

This block scans a switch matrix of columns and rows with one active-high column drive at a time, stepping to the next column on every clock while no switch is closed. When a sensed row reads high, the block stops the scan on that column, turns the column and row position into an 8-bit character code shaped by the modifier keys, and pulls an active-low data-ready flag. A host reads the code through a four-input select port. The read clears the data-ready flag on the same clock edge.

While the key is held after the read, an active-low repeat flag stays low so the host can run auto-repeat. Once the key opens, a release timer holds the scan for a set number of clocks, and only then does scanning resume. Control, shift and an alpha-lock level change the decoding with a fixed priority. They never make a code by themselves. The tri-state bus is modelled as a gated code output plus an enable.

Top module: `kbd_encoder`

## Requirements
- R1: After reset `col_drive` is one-hot on column 0. With no switch closed it advances by one column per clock, wrapping from the last column back to column 0.
- R2: If any `row_sense` bit is high during scanning, the next clock edge pulls `ready_n` low and the drive freezes on that column. When several rows are high together, the lowest row index is taken.
- R3: The position value is `col*8 + row` (7 bits), and code bit 7 is always 0. A position is a letter when bit 6 is 1 and bits 4:0 lie in 1..26.
- R4: With no modifier active, a letter gives the position with bit 5 set (lower case), and any other key gives the position unchanged.
- R5: With shift active and control inactive, a letter gives the lower-case value with bit 5 inverted. A non-letter is unchanged.
- R6: With control active, the code is the lower-case-rule value with bits 6:5 cleared, whatever shift and alpha are.
- R7: With alpha high and neither shift nor control active, a letter gives the position with bit 5 clear and a non-letter is unchanged. Alpha is sampled live at detection. Shift and control are taken from a register loaded on every scanning clock and frozen while a key is held or settling.
- R8: `code_oe` is high and `code_out` carries the code only while all four `sel` bits are 1. Otherwise `code_oe` is 0 and `code_out` is 0.
- R9: `ready_n` returns high on a clock edge at which all four `sel` bits are 1. A read with fewer selects leaves it low.
- R10: `repeat_n` is low while the detected key stays closed after `ready_n` went high. It returns high on the first edge after the key opens.
- R11: After release the drive stays on the same column for `SETTLE_CYC` clocks, then moves to the next column. A closure seen during that window restarts the wait.
- R12: While a key is held, a second key in another column sets no new `ready_n` and leaves the stored code unchanged. It is found only after the first key is released and has settled.
- R13: Toggling shift, control or alpha with no switch closed never pulls `ready_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| col_drive | output | N_COL | One-hot column drive |
| row_sense | input | N_ROW | Row sense lines, high when a driven switch is closed |
| mod_shift | input | 1 | Shift modifier |
| mod_ctrl | input | 1 | Control modifier |
| mod_alpha | input | 1 | Alpha-lock level |
| sel | input | 4 | Read selects, all high to read |
| code_out | output | 8 | Character code, zero when not selected |
| code_oe | output | 1 | Read port enable |
| ready_n | output | 1 | Data-ready flag, active low |
| repeat_n | output | 1 | Key-still-held flag, active low |

## Verification
The bench keeps the default 11 by 8 matrix, so column indices 8 to 10 produce the letter range and every modifier path is reachable. It sets `SETTLE_CYC` to 6. That is long enough to drop a bounce inside the window and short enough to check the exact cycle at which the frozen column is released. A small settle count also lets many random key and modifier combinations fit in a short run.

// File: rtl/kbd_enc_pkg.sv
package kbd_enc_pkg;

    typedef enum logic [1:0] {
        ST_SCAN   = 2'd0,
        ST_HOLD   = 2'd1,
        ST_SETTLE = 2'd2
    } scan_st_e;

    typedef enum logic [1:0] {
        MD_PLAIN = 2'd0,
        MD_ALPHA = 2'd1,
        MD_SHIFT = 2'd2,
        MD_CTRL  = 2'd3
    } mod_mode_e;

    localparam int CODE_W = 8;
    localparam int POS_W  = 7;

    // Fixed priority: control, then shift, then alpha, then plain.
    function automatic mod_mode_e pick_mode(input logic ctrl, input logic shift,
                                            input logic alpha);
        mod_mode_e m;
        if (ctrl)       m = MD_CTRL;
        else if (shift) m = MD_SHIFT;
        else if (alpha) m = MD_ALPHA;
        else            m = MD_PLAIN;
        return m;
    endfunction

endpackage

// File: rtl/kbd_row_pick.sv
module kbd_row_pick #(
    parameter int N_ROW = 8,
    localparam int ROW_W = (N_ROW > 1) ? $clog2(N_ROW) : 1
) (
    input  logic [N_ROW-1:0] sense,
    output logic             hit,
    output logic [ROW_W-1:0] idx
);
    // Chain of priority stages: lowest index wins.
    logic [ROW_W-1:0] stage_idx [N_ROW+1];
    logic             stage_hit [N_ROW+1];

    assign stage_idx[N_ROW] = '0;
    assign stage_hit[N_ROW] = 1'b0;

    for (genvar i = N_ROW - 1; i >= 0; i--) begin : g_stage
        assign stage_hit[i] = sense[i] | stage_hit[i+1];
        assign stage_idx[i] = sense[i] ? ROW_W'(i) : stage_idx[i+1];
    end

    assign hit = stage_hit[0];
    assign idx = stage_idx[0];
endmodule

// File: rtl/kbd_code_map.sv
module kbd_code_map
    import kbd_enc_pkg::*;
#(
    parameter int N_COL = 11,
    parameter int N_ROW = 8,
    localparam int COL_W = (N_COL > 1) ? $clog2(N_COL) : 1,
    localparam int ROW_W = (N_ROW > 1) ? $clog2(N_ROW) : 1
) (
    input  logic [COL_W-1:0]  col,
    input  logic [ROW_W-1:0]  row,
    input  mod_mode_e         mode,
    output logic [CODE_W-1:0] code
);
    logic [POS_W-1:0] pos;
    logic             is_letter;
    logic [POS_W-1:0] lower;
    logic [POS_W-1:0] shaped;

    always_comb begin
        pos       = POS_W'(int'(col) * N_ROW + int'(row));
        is_letter = pos[6] && (pos[4:0] >= 5'd1) && (pos[4:0] <= 5'd26);
        lower     = is_letter ? (pos | 7'h20) : pos;
        unique case (mode)
            MD_CTRL:  shaped = lower & 7'h1F;
            MD_SHIFT: shaped = is_letter ? (lower ^ 7'h20) : lower;
            MD_ALPHA: shaped = is_letter ? (pos & 7'h5F) : pos;
            default:  shaped = lower;
        endcase
        code = {1'b0, shaped};
    end
endmodule

// File: rtl/kbd_release_timer.sv
module kbd_release_timer #(
    parameter int SETTLE_CYC = 16,
    localparam int CNT_W = $clog2(SETTLE_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)              cnt_d = CNT_W'(SETTLE_CYC);
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/kbd_encoder.sv
module kbd_encoder
    import kbd_enc_pkg::*;
#(
    parameter int N_COL      = 11,
    parameter int N_ROW      = 8,
    parameter int SETTLE_CYC = 16,
    localparam int COL_W = (N_COL > 1) ? $clog2(N_COL) : 1,
    localparam int ROW_W = (N_ROW > 1) ? $clog2(N_ROW) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [N_COL-1:0]  col_drive,
    input  logic [N_ROW-1:0]  row_sense,
    input  logic              mod_shift,
    input  logic              mod_ctrl,
    input  logic              mod_alpha,
    input  logic [3:0]        sel,
    output logic [CODE_W-1:0] code_out,
    output logic              code_oe,
    output logic              ready_n,
    output logic              repeat_n
);
    typedef struct packed {
        scan_st_e          st;
        logic [COL_W-1:0]  col;
        logic [CODE_W-1:0] code;
        logic              ready_n;
        logic              repeat_n;
        logic              shift;
        logic              ctrl;
    } enc_state_t;

    enc_state_t st_d, st_q;

    logic              key_hit;
    logic [ROW_W-1:0]  key_row;
    logic [CODE_W-1:0] key_code;
    logic              tmr_load;
    logic              tmr_expired;
    logic              rd_sel;
    logic [COL_W-1:0]  col_next;
    mod_mode_e         mode;

    kbd_row_pick #(.N_ROW(N_ROW)) u_pick (
        .sense (row_sense),
        .hit   (key_hit),
        .idx   (key_row)
    );

    assign mode = pick_mode(st_q.ctrl, st_q.shift, mod_alpha);

    kbd_code_map #(.N_COL(N_COL), .N_ROW(N_ROW)) u_map (
        .col  (st_q.col),
        .row  (key_row),
        .mode (mode),
        .code (key_code)
    );

    kbd_release_timer #(.SETTLE_CYC(SETTLE_CYC)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .expired (tmr_expired)
    );

    assign rd_sel   = &sel;
    assign col_next = (st_q.col == COL_W'(N_COL - 1)) ? '0 : st_q.col + 1'b1;
    assign tmr_load = ((st_q.st == ST_HOLD) && !key_hit) ||
                      ((st_q.st == ST_SETTLE) && key_hit);

    always_comb begin
        st_d = st_q;
        unique case (st_q.st)
            ST_SCAN: begin
                st_d.shift = mod_shift;
                st_d.ctrl  = mod_ctrl;
                if (key_hit) begin
                    st_d.st   = ST_HOLD;
                    st_d.code = key_code;
                end else begin
                    st_d.col  = col_next;
                end
            end
            ST_HOLD: begin
                if (!key_hit) st_d.st = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (!key_hit && tmr_expired) begin
                    st_d.st  = ST_SCAN;
                    st_d.col = col_next;
                end
            end
            default: st_d.st = ST_SCAN;
        endcase

        if ((st_q.st == ST_SCAN) && key_hit) st_d.ready_n = 1'b0;
        else if (rd_sel)                     st_d.ready_n = 1'b1;

        st_d.repeat_n = !((st_d.st == ST_HOLD) && st_d.ready_n);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.st       <= ST_SCAN;
            st_q.col      <= '0;
            st_q.code     <= '0;
            st_q.ready_n  <= 1'b1;
            st_q.repeat_n <= 1'b1;
            st_q.shift    <= 1'b0;
            st_q.ctrl     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar c = 0; c < N_COL; c++) begin : g_drive
        assign col_drive[c] = (st_q.col == COL_W'(c));
    end

    assign code_oe  = rd_sel;
    assign code_out = rd_sel ? st_q.code : '0;
    assign ready_n  = st_q.ready_n;
    assign repeat_n = st_q.repeat_n;
endmodule

// File: rtl/kbd_encoder_chk.sv
module kbd_encoder_chk #(
    parameter int N_COL = 11,
    parameter int N_ROW = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_COL-1:0] col_drive,
    input logic [N_ROW-1:0] row_sense,
    input logic [3:0]       sel,
    input logic [7:0]       code_out,
    input logic             code_oe,
    input logic             ready_n,
    input logic             repeat_n
);
    a_r1_one_column: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(col_drive) == 1);

    a_r2_ready_needs_sense: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready_n) |-> $past(|row_sense));

    a_r3_top_bit_clear: assert property (@(posedge clk) disable iff (!rst_n)
        code_out[7] == 1'b0);

    a_r8_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !code_oe |-> (code_out == 8'h00));

    a_r9_clear_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_n) |-> $past(&sel));

    a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready_n == 1'b0 && repeat_n == 1'b0));

    a_r12_column_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !repeat_n |=> $stable(col_drive));
endmodule

bind kbd_encoder kbd_encoder_chk #(.N_COL(N_COL), .N_ROW(N_ROW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .col_drive (col_drive),
    .row_sense (row_sense),
    .sel       (sel),
    .code_out  (code_out),
    .code_oe   (code_oe),
    .ready_n   (ready_n),
    .repeat_n  (repeat_n)
);

// File: tb/kbd_encoder_test.sv
module kbd_encoder_test;
    localparam int CLK_PERIOD = 10;
    localparam int NC  = 11;
    localparam int NR  = 8;
    localparam int DEB = 6;
    localparam int WATCHDOG = 100000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NC-1:0] col_drive;
    logic [NR-1:0] row_sense;
    logic          mod_shift = 1'b0, mod_ctrl = 1'b0, mod_alpha = 1'b0;
    logic [3:0]    sel = 4'h0;
    logic [7:0]    code_out;
    logic          code_oe, ready_n, repeat_n;
    logic [NR-1:0] keys [NC];

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    always_comb begin
        row_sense = '0;
        for (int c = 0; c < NC; c++)
            if (col_drive[c]) row_sense = row_sense | keys[c];
    end

    kbd_encoder #(.N_COL(NC), .N_ROW(NR), .SETTLE_CYC(DEB)) uut (
        .clk(clk), .rst_n(rst_n), .col_drive(col_drive), .row_sense(row_sense),
        .mod_shift(mod_shift), .mod_ctrl(mod_ctrl), .mod_alpha(mod_alpha),
        .sel(sel), .code_out(code_out), .code_oe(code_oe),
        .ready_n(ready_n), .repeat_n(repeat_n)
    );

    function automatic logic [7:0] exp_code(int c, int r, bit ct, bit sh, bit al);
        logic [6:0] p, lo, v;
        bit letter;
        p = 7'(c * 8 + r);
        letter = p[6] && p[4:0] >= 5'd1 && p[4:0] <= 5'd26;
        lo = letter ? (p | 7'h20) : p;
        if (ct)      v = lo & 7'h1F;
        else if (sh) v = letter ? (lo ^ 7'h20) : lo;
        else if (al) v = letter ? (p & 7'h5F) : p;
        else         v = lo;
        return {1'b0, v};
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_ready(output bit got);
        got = 1'b0;
        for (int i = 0; i < 4 * NC; i++) begin
            @(negedge clk);
            if (!ready_n) begin got = 1'b1; break; end
        end
    endtask

    task automatic do_read(input logic [3:0] s, output logic [7:0] val, output logic oe);
        @(negedge clk);
        sel = s;
        #1;
        val = code_out;
        oe  = code_oe;
        @(negedge clk);
        sel = 4'h0;
    endtask

    task automatic clear_keys();
        for (int c = 0; c < NC; c++) keys[c] = '0;
    endtask

    // Press, detect, read, release with settle timing; modifiers set in advance.
    task automatic key_cycle(int c, int r, bit ct, bit sh, bit al);
        bit got;
        logic [7:0] v;
        logic oe;
        @(negedge clk);
        mod_ctrl = ct; mod_shift = sh; mod_alpha = al;
        repeat (3) @(negedge clk);
        keys[c][r] = 1'b1;
        wait_ready(got);
        check(got, "R2 ready_n low on closure", ready_n, 0);
        check(col_drive == NC'(1) << c, "R2 drive frozen on key column", col_drive, NC'(1) << c);
        do_read(4'hF, v, oe);
        check(oe && v == exp_code(c, r, ct, sh, al), "R3 R4 R5 R6 R7 code value", v, exp_code(c, r, ct, sh, al));
        check(ready_n == 1'b1, "R9 ready_n cleared by read", ready_n, 1);
        check(repeat_n == 1'b0, "R10 repeat_n low while held", repeat_n, 0);
        @(negedge clk);
        keys[c][r] = 1'b0;
        @(negedge clk);
        check(repeat_n == 1'b1, "R10 repeat_n high after release", repeat_n, 1);
        repeat (DEB - 1) @(negedge clk);
        check(col_drive == NC'(1) << c, "R11 column held during settle", col_drive, NC'(1) << c);
        @(negedge clk);
        check(col_drive == NC'(1) << ((c + 1) % NC), "R11 scan resumes at next column",
              col_drive, NC'(1) << ((c + 1) % NC));
        mod_ctrl = 1'b0; mod_shift = 1'b0; mod_alpha = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        bit got, ok;
        logic [7:0] v;
        logic oe;
        int start;
        void'($urandom(32'h5EED_1234));
        clear_keys();
        repeat (3) @(negedge clk);
        check(col_drive == NC'(1) && ready_n && repeat_n && !code_oe && code_out == 0,
              "R1 reset state", {col_drive, ready_n, repeat_n}, {NC'(1), 2'b11});
        rst_n = 1'b1;

        // R1: free scan order and wrap.
        @(negedge clk);
        start = -1;
        for (int c = 0; c < NC; c++) if (col_drive[c]) start = c;
        ok = 1'b1;
        for (int i = 1; i <= 2 * NC; i++) begin
            @(negedge clk);
            if (col_drive != NC'(1) << ((start + i) % NC)) ok = 1'b0;
        end
        check(ok, "R1 column advances and wraps", col_drive, 0);

        // R13: modifiers alone never produce a code.
        ok = 1'b1;
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            mod_shift = i[0]; mod_ctrl = i[1]; mod_alpha = i[2];
            if (!ready_n) ok = 1'b0;
        end
        check(ok, "R13 modifiers alone leave ready_n high", ready_n, 1);
        mod_shift = 0; mod_ctrl = 0; mod_alpha = 0;
        repeat (2) @(negedge clk);

        // Directed letter and non-letter keys under each mode.
        key_cycle(8, 1, 0, 0, 0);   // R4 letter lower case
        key_cycle(8, 1, 0, 1, 0);   // R5 shift letter
        key_cycle(8, 1, 0, 0, 1);   // R7 alpha letter
        key_cycle(9, 2, 1, 1, 1);   // R6 control overrides
        key_cycle(6, 1, 0, 1, 1);   // R5 shift on non-letter
        key_cycle(6, 1, 0, 0, 1);   // R7 alpha on non-letter
        key_cycle(10, 7, 0, 0, 0);  // R4 last position, non-letter
        key_cycle(0, 0, 0, 0, 0);   // R3 first position

        // R2: lowest row wins when two rows close together.
        @(negedge clk);
        keys[4][6] = 1'b1; keys[4][2] = 1'b1;
        wait_ready(got);
        do_read(4'hF, v, oe);
        check(v == exp_code(4, 2, 0, 0, 0), "R2 lowest row taken", v, exp_code(4, 2, 0, 0, 0));
        @(negedge clk);
        clear_keys();
        repeat (DEB + 4) @(negedge clk);

        // R8, R9: partial selects do not read or clear.
        @(negedge clk);
        keys[3][5] = 1'b1;
        wait_ready(got);
        do_read(4'b0111, v, oe);
        check(!oe && v == 0, "R8 port off with partial select", {oe, v}, 0);
        do_read(4'b1110, v, oe);
        check(ready_n == 1'b0, "R9 partial select keeps ready_n low", ready_n, 0);

        // R12: lockout of a second key while the first is held.
        do_read(4'hF, v, oe);
        check(v == exp_code(3, 5, 0, 0, 0), "R8 full select reads code", v, exp_code(3, 5, 0, 0, 0));
        @(negedge clk);
        keys[7][3] = 1'b1;
        ok = 1'b1;
        repeat (3 * NC) begin
            @(negedge clk);
            if (!ready_n || col_drive != NC'(1) << 3) ok = 1'b0;
        end
        check(ok, "R12 second key ignored while held", ready_n, 1);
        do_read(4'hF, v, oe);
        check(v == exp_code(3, 5, 0, 0, 0), "R12 stored code unchanged", v, exp_code(3, 5, 0, 0, 0));
        keys[3][5] = 1'b0;
        wait_ready(got);
        check(got && col_drive == NC'(1) << 7, "R12 second key found after settle", col_drive, NC'(1) << 7);
        do_read(4'hF, v, oe);
        check(v == exp_code(7, 3, 0, 0, 0), "R12 second key code", v, exp_code(7, 3, 0, 0, 0));
        @(negedge clk);
        keys[7][3] = 1'b0;

        // R11: a bounce during settle restarts the wait.
        repeat (DEB - 2) @(negedge clk);
        keys[7][3] = 1'b1;
        repeat (3) @(negedge clk);
        check(col_drive == NC'(1) << 7 && ready_n && repeat_n, "R11 bounce keeps column and flags",
              {col_drive, ready_n, repeat_n}, {NC'(1) << 7, 2'b11});
        keys[7][3] = 1'b0;
        repeat (DEB - 2) @(negedge clk);
        check(col_drive == NC'(1) << 7, "R11 settle restarted after bounce", col_drive, NC'(1) << 7);
        repeat (4) @(negedge clk);
        check(col_drive != NC'(1) << 7, "R11 scan leaves after full settle", col_drive, 0);
        repeat (NC) @(negedge clk);

        // Random keys and modifier mixes.
        for (int i = 0; i < 60; i++) begin
            int c, r;
            bit ct, sh, al;
            c  = int'($urandom % NC);
            r  = int'($urandom % NR);
            ct = ($urandom % 4) == 0;
            sh = ($urandom % 3) == 0;
            al = ($urandom % 2) == 0;
            key_cycle(c, r, ct, sh, al);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        wait (cycles >= WATCHDOG);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=<%0d", cycles, WATCHDOG);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule